// File: doc/BRIEF.md
# Subscriber Line State Sequencer

This block is the digital controller that sits beside a telephone line interface device and runs one subscriber line. It drives the device's four mode pins (power-down enable and three data bits) and watches the device's active-low detector output. From these it walks the line between power down, high-impedance idle, active talk and ringing. While ringing it builds the ring signal itself: it flips the polarity bit at the ring frequency during a burst, holds it low during a pause, and repeats the burst/pause cadence until the phone is answered or the host stops it.

The detector line means different things in different states. In idle and talk it reports the hook state, and in ringing it reports a ring trip. The controller first passes it through a two-flop synchronizer and a programmable debounce. A thermal alarm input forces the pins to the power-down code without losing the logical state, and a host power-down request cuts the line in any state. Ring half-period, burst length, pause length, the on-hook return time and the debounce time are counts of clock cycles held in registers the host can write. Their reset values come from the clock-frequency parameter.

Top module: `line_seq`

## Requirements
- R1: The mode pins {pd,d0,d1,d2} take only these codes: 0000 power down, 1000 idle (high-impedance feed), 101p active with p the polarity (0 normal, 1 reversed), 110r ringing with r the ring phase. After reset the pins show idle, 1000.
- R2: In idle, a debounced low detector level moves the line to active with normal polarity (1010).
- R3: A pol_req strobe in active flips d2. In idle, ringing or power down it has no effect. Every entry into active starts with normal polarity.
- R4: In active, once the debounced detector level has been high (on-hook) for tref consecutive cycles, the line returns to idle.
- R5: A ring_req strobe in idle starts ringing with d2=0. d2 then toggles every half cycles during a burst. ring_req is ignored outside idle, and an off-hook level in idle takes priority over it.
- R6: A burst lasts burst cycles and a pause lasts pause cycles. d2 is 0 throughout a pause, and a new burst follows each pause.
- R7: In ringing, a debounced low detector level (ring trip) moves the line to active normal (1010) on the next clock edge, ending the toggling at once.
- R8: A stop_req strobe during a burst lets the current half-period run to its end, and the line then goes to idle with d2=0. During a pause the line goes to idle within two cycles.
- R9: A pwrdn_req strobe in any state gives 0000 on the next cycle. In power down the detector is ignored, and only wake_req leaves it, to idle.
- R10: While therm_alarm is high the pins show 0000 from the next cycle on, and the sequencer's state and timers are frozen. When the alarm drops, the pins of the saved state return on the next cycle.
- R11: The detector input is synchronized through two flip-flops. A level change is acted on only after it has been stable for deb consecutive cycles, so shorter pulses are ignored.
- R12: A cfg_we strobe writes cfg_data to the timing register chosen by cfg_sel: 0 half-period, 1 burst, 2 pause, 3 tref, 4 debounce. Other codes are ignored, and a written value of 0 is stored as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_req | input | 1 | Strobe: start ringing from idle |
| stop_req | input | 1 | Strobe: end ringing cleanly |
| pwrdn_req | input | 1 | Strobe: emergency power down |
| wake_req | input | 1 | Strobe: leave power down to idle |
| pol_req | input | 1 | Strobe: flip polarity in active |
| det_n | input | 1 | Detector from line device, active low, asynchronous |
| therm_alarm | input | 1 | Thermal shutdown indication, active high |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 3 | Timing register select |
| cfg_data | input | 32 | Timing value in clock cycles |
| pd | output | 1 | Power-down enable pin (0 = powered down) |
| d0 | output | 1 | Mode data bit 0 |
| d1 | output | 1 | Mode data bit 1 |
| d2 | output | 1 | Mode data bit 2, polarity / ring phase |

## Verification
The ring cadence is sampled at chosen cycles inside the first burst, in the pause and after the pause ends. This separates a wrong half-period count, a toggle that leaks into the pause and a pause that never ends. The detector is driven low while idle, active, ringing and powered down, and with a pulse shorter than the debounce time, so the different meanings of the detector show up apart, including the case where it must be ignored. A stop request is given both mid-burst and in a pause, telling a clean half-period finish from an abrupt cut. A thermal alarm raised mid-burst shows whether the ring phase is held and restored rather than reset.

// File: rtl/line_seq_pkg.sv
package line_seq_pkg;
    localparam int TW    = 32;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ST_PDN    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_RING   = 2'd3
    } line_st_e;

    typedef enum logic {
        PH_BURST = 1'b0,
        PH_PAUSE = 1'b1
    } ring_ph_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_HALF  = 3'd0,
        SEL_BURST = 3'd1,
        SEL_PAUSE = 3'd2,
        SEL_TREF  = 3'd3,
        SEL_DEB   = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic pd;
        logic d0;
        logic d1;
        logic d2;
    } mode_pins_t;

    typedef struct packed {
        logic [TW-1:0] half;
        logic [TW-1:0] burst;
        logic [TW-1:0] pause;
        logic [TW-1:0] tref;
        logic [TW-1:0] deb;
    } timing_t;

    localparam mode_pins_t PINS_OFF = '{pd: 1'b0, d0: 1'b0, d1: 1'b0, d2: 1'b0};

    function automatic mode_pins_t encode_mode(line_st_e st, logic pol);
        mode_pins_t m;
        case (st)
            ST_IDLE:   m = '{pd: 1'b1, d0: 1'b0, d1: 1'b0, d2: 1'b0};
            ST_ACTIVE: m = '{pd: 1'b1, d0: 1'b0, d1: 1'b1, d2: pol};
            ST_RING:   m = '{pd: 1'b1, d0: 1'b1, d1: 1'b0, d2: pol};
            default:   m = PINS_OFF;
        endcase
        return m;
    endfunction

    function automatic logic [TW-1:0] at_least_one(logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction
endpackage

// File: rtl/line_seq_cfg.sv
module line_seq_cfg
    import line_seq_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [TW-1:0]    data,
    output timing_t          tm
);
    localparam longint HZ = longint'(CLK_HZ);
    localparam logic [TW-1:0] DEF_HALF  = TW'(HZ / 50);
    localparam logic [TW-1:0] DEF_BURST = TW'(HZ);
    localparam logic [TW-1:0] DEF_PAUSE = TW'(HZ * 4);
    localparam logic [TW-1:0] DEF_TREF  = TW'(HZ / 5);
    localparam logic [TW-1:0] DEF_DEB   = TW'(HZ / 100);

    logic [TW-1:0] wval;
    assign wval = at_least_one(data);

    always_ff @(posedge clk) begin
        if (rst) begin
            tm.half  <= at_least_one(DEF_HALF);
            tm.burst <= at_least_one(DEF_BURST);
            tm.pause <= at_least_one(DEF_PAUSE);
            tm.tref  <= at_least_one(DEF_TREF);
            tm.deb   <= at_least_one(DEF_DEB);
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_HALF:  tm.half  <= wval;
                SEL_BURST: tm.burst <= wval;
                SEL_PAUSE: tm.pause <= wval;
                SEL_TREF:  tm.tref  <= wval;
                SEL_DEB:   tm.deb   <= wval;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/line_seq_detfilt.sv
module line_seq_detfilt
    import line_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          det_n,
    input  logic [TW-1:0] deb,
    output logic          lvl
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [TW-1:0]          cnt;
    logic                   s_out;

    assign s_out = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], det_n};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b1;
            cnt <= '0;
        end else if (s_out == lvl) begin
            cnt <= '0;
        end else if (cnt >= deb - TW'(1)) begin
            lvl <= s_out;
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/line_seq_cadence.sv
module line_seq_cadence
    import line_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          stop,
    input  logic [TW-1:0] half,
    input  logic [TW-1:0] burst,
    input  logic [TW-1:0] pause,
    output logic          d2,
    output logic          in_pause,
    output logic          done
);
    ring_ph_e      phase;
    logic [TW-1:0] half_cnt;
    logic [TW-1:0] ph_cnt;
    logic          stopping;
    logic          half_end, burst_end, pause_end;

    assign in_pause  = (phase == PH_PAUSE);
    assign half_end  = (half_cnt >= half - TW'(1));
    assign burst_end = (phase == PH_BURST) && (ph_cnt >= burst - TW'(1));
    assign pause_end = (phase == PH_PAUSE) && (ph_cnt >= pause - TW'(1));
    assign done      = run && stopping && (in_pause || half_end || burst_end);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase    <= PH_BURST;
            half_cnt <= '0;
            ph_cnt   <= '0;
            stopping <= 1'b0;
            d2       <= 1'b0;
        end else if (run) begin
            stopping <= stopping | stop;
            if (done) begin
                d2 <= 1'b0;
            end else if (phase == PH_BURST) begin
                if (burst_end) begin
                    phase    <= PH_PAUSE;
                    ph_cnt   <= '0;
                    half_cnt <= '0;
                    d2       <= 1'b0;
                end else begin
                    ph_cnt <= ph_cnt + TW'(1);
                    if (half_end) begin
                        half_cnt <= '0;
                        d2       <= ~d2;
                    end else begin
                        half_cnt <= half_cnt + TW'(1);
                    end
                end
            end else begin
                if (pause_end) begin
                    phase    <= PH_BURST;
                    ph_cnt   <= '0;
                    half_cnt <= '0;
                end else begin
                    ph_cnt <= ph_cnt + TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/line_seq.sv
module line_seq
    import line_seq_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ring_req,
    input  logic             stop_req,
    input  logic             pwrdn_req,
    input  logic             wake_req,
    input  logic             pol_req,
    input  logic             det_n,
    input  logic             therm_alarm,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [TW-1:0]    cfg_data,
    output logic             pd,
    output logic             d0,
    output logic             d1,
    output logic             d2
);
    timing_t       tm;
    line_st_e      state, nxt;
    logic          alarm_q;
    logic          pol_q;
    logic [TW-1:0] tref_cnt;
    logic          det_lvl;
    logic          cad_d2, cad_pause, cad_done;
    logic          cad_run, cad_clear;
    mode_pins_t    pins;

    line_seq_cfg #(.CLK_HZ(CLK_HZ)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .data(cfg_data), .tm(tm)
    );

    line_seq_detfilt #(.SYNC_STAGES(2)) u_det (
        .clk(clk), .rst(rst), .det_n(det_n), .deb(tm.deb), .lvl(det_lvl)
    );

    assign cad_run   = (state == ST_RING) && !alarm_q;
    assign cad_clear = (state != ST_RING);

    line_seq_cadence u_cad (
        .clk(clk), .rst(rst), .clear(cad_clear), .run(cad_run), .stop(stop_req),
        .half(tm.half), .burst(tm.burst), .pause(tm.pause),
        .d2(cad_d2), .in_pause(cad_pause), .done(cad_done)
    );

    always_ff @(posedge clk) begin
        if (rst) alarm_q <= 1'b0;
        else     alarm_q <= therm_alarm;
    end

    always_comb begin
        nxt = state;
        if (pwrdn_req) begin
            nxt = ST_PDN;
        end else if (!alarm_q) begin
            case (state)
                ST_PDN:    if (wake_req) nxt = ST_IDLE;
                ST_IDLE: begin
                    if (!det_lvl)      nxt = ST_ACTIVE;
                    else if (ring_req) nxt = ST_RING;
                end
                ST_ACTIVE: if (det_lvl && (tref_cnt >= tm.tref - TW'(1))) nxt = ST_IDLE;
                ST_RING: begin
                    if (!det_lvl)      nxt = ST_ACTIVE;
                    else if (cad_done) nxt = ST_IDLE;
                end
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pol_q    <= 1'b0;
            tref_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_ACTIVE && state != ST_ACTIVE)
                pol_q <= 1'b0;
            else if (state == ST_ACTIVE && pol_req && !alarm_q)
                pol_q <= ~pol_q;
            if (state != ST_ACTIVE || !det_lvl)
                tref_cnt <= '0;
            else if (!alarm_q)
                tref_cnt <= tref_cnt + TW'(1);
        end
    end

    assign pins = alarm_q ? PINS_OFF
                          : encode_mode(state, (state == ST_RING) ? cad_d2 : pol_q);
    assign pd = pins.pd;
    assign d0 = pins.d0;
    assign d1 = pins.d1;
    assign d2 = pins.d2;
endmodule

// File: rtl/line_seq_chk.sv
module line_seq_chk
    import line_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       pwrdn_req,
    input logic       wake_req,
    input logic       therm_alarm,
    input logic       pd,
    input logic       d0,
    input logic       d1,
    input logic       d2,
    input logic [1:0] st,
    input logic       in_pause,
    input logic       det_lvl,
    input logic       alarm_q
);
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (rst)
        !(d0 && d1) && (pd || (!d0 && !d1 && !d2)));

    assert_pause_low_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RING && in_pause) |-> !d2);

    assert_trip_to_active_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RING && !det_lvl && !alarm_q && !pwrdn_req) |=> (pd && !d0 && d1 && !d2));

    assert_pdn_cut_R9: assert property (@(posedge clk) disable iff (rst)
        pwrdn_req |=> (!pd && !d0 && !d1 && !d2));

    assert_pdn_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PDN && !wake_req) |=> (st == ST_PDN));

    assert_alarm_off_R10: assert property (@(posedge clk) disable iff (rst)
        therm_alarm |=> (!pd && !d0 && !d1 && !d2));
endmodule

bind line_seq line_seq_chk u_chk (
    .clk(clk), .rst(rst), .pwrdn_req(pwrdn_req), .wake_req(wake_req),
    .therm_alarm(therm_alarm), .pd(pd), .d0(d0), .d1(d1), .d2(d2),
    .st(state), .in_pause(cad_pause), .det_lvl(det_lvl), .alarm_q(alarm_q)
);

// File: tb/line_seq_test.sv
module line_seq_test;
    import line_seq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ring_req = 0, stop_req = 0, pwrdn_req = 0, wake_req = 0, pol_req = 0;
    logic det_n = 1'b1, therm_alarm = 1'b0;
    logic cfg_we = 0;
    logic [SEL_W-1:0] cfg_sel = '0;
    logic [TW-1:0] cfg_data = '0;
    logic pd, d0, d1, d2;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    line_seq uut (
        .clk(clk), .rst(rst), .ring_req(ring_req), .stop_req(stop_req),
        .pwrdn_req(pwrdn_req), .wake_req(wake_req), .pol_req(pol_req),
        .det_n(det_n), .therm_alarm(therm_alarm), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .pd(pd), .d0(d0), .d1(d1), .d2(d2)
    );

    localparam logic [2:0] OP_NONE = 3'd0, OP_RING = 3'd1, OP_STOP = 3'd2,
                           OP_PDN = 3'd3, OP_WAKE = 3'd4, OP_POL = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic        det;
        logic        alm;
        logic [15:0] n;
        logic [3:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 38;
    // timing used: half 4, burst 40, pause 30, tref 50, debounce 5
    localparam vec_t VECS [NV] = '{
        '{OP_NONE, 1'b1, 1'b0, 16'd4,  4'b1000, 8'd1},  // R1 idle
        '{OP_PDN,  1'b1, 1'b0, 16'd2,  4'b0000, 8'd9},  // R9 cut
        '{OP_NONE, 1'b0, 1'b0, 16'd29, 4'b0000, 8'd9},  // R9 det ignored
        '{OP_NONE, 1'b1, 1'b0, 16'd19, 4'b0000, 8'd9},
        '{OP_WAKE, 1'b1, 1'b0, 16'd2,  4'b1000, 8'd9},  // R9 wake
        '{OP_NONE, 1'b0, 1'b0, 16'd19, 4'b1010, 8'd2},  // R2 off-hook
        '{OP_POL,  1'b0, 1'b0, 16'd2,  4'b1011, 8'd3},  // R3 reverse
        '{OP_POL,  1'b0, 1'b0, 16'd2,  4'b1010, 8'd3},  // R3 normal
        '{OP_NONE, 1'b1, 1'b0, 16'd19, 4'b1010, 8'd4},  // R4 before tref
        '{OP_NONE, 1'b1, 1'b0, 16'd59, 4'b1000, 8'd4},  // R4 after tref
        '{OP_RING, 1'b1, 1'b0, 16'd2,  4'b1100, 8'd5},  // R5 start low
        '{OP_NONE, 1'b1, 1'b0, 16'd1,  4'b1101, 8'd5},  // R5 E4 toggle
        '{OP_NONE, 1'b1, 1'b0, 16'd3,  4'b1100, 8'd5},  // R5 E8
        '{OP_NONE, 1'b1, 1'b0, 16'd29, 4'b1101, 8'd6},  // R6 E38 burst
        '{OP_NONE, 1'b1, 1'b0, 16'd6,  4'b1100, 8'd6},  // R6 E45 pause
        '{OP_NONE, 1'b1, 1'b0, 16'd30, 4'b1101, 8'd6},  // R6 E76 burst again
        '{OP_NONE, 1'b0, 1'b0, 16'd19, 4'b1010, 8'd7},  // R7 ring trip
        '{OP_NONE, 1'b1, 1'b0, 16'd69, 4'b1000, 8'd4},
        '{OP_RING, 1'b1, 1'b0, 16'd5,  4'b1101, 8'd5},
        '{OP_STOP, 1'b1, 1'b0, 16'd1,  4'b1101, 8'd8},  // R8 half runs out
        '{OP_NONE, 1'b1, 1'b0, 16'd1,  4'b1000, 8'd8},  // R8 idle
        '{OP_RING, 1'b1, 1'b0, 16'd44, 4'b1100, 8'd6},
        '{OP_STOP, 1'b1, 1'b0, 16'd2,  4'b1000, 8'd8},  // R8 stop in pause
        '{OP_RING, 1'b1, 1'b0, 16'd5,  4'b1101, 8'd5},
        '{OP_NONE, 1'b1, 1'b1, 16'd2,  4'b0000, 8'd10}, // R10 forced off
        '{OP_NONE, 1'b1, 1'b1, 16'd49, 4'b0000, 8'd10},
        '{OP_NONE, 1'b1, 1'b0, 16'd0,  4'b1101, 8'd10}, // R10 restored
        '{OP_STOP, 1'b1, 1'b0, 16'd10, 4'b1000, 8'd8},
        '{OP_NONE, 1'b0, 1'b0, 16'd2,  4'b1000, 8'd11}, // R11 short pulse
        '{OP_NONE, 1'b1, 1'b0, 16'd19, 4'b1000, 8'd11},
        '{OP_POL,  1'b1, 1'b0, 16'd2,  4'b1000, 8'd3},  // R3 ignored idle
        '{OP_NONE, 1'b0, 1'b0, 16'd19, 4'b1010, 8'd2},
        '{OP_RING, 1'b0, 1'b0, 16'd2,  4'b1010, 8'd5},  // R5 ignored active
        '{OP_NONE, 1'b1, 1'b0, 16'd69, 4'b1000, 8'd4},
        '{OP_RING, 1'b1, 1'b0, 16'd1,  4'b1100, 8'd5},
        '{OP_PDN,  1'b1, 1'b0, 16'd0,  4'b0000, 8'd9},  // R9 from ringing
        '{OP_RING, 1'b1, 1'b0, 16'd3,  4'b0000, 8'd5},  // R5 ignored in pdn
        '{OP_WAKE, 1'b1, 1'b0, 16'd2,  4'b1000, 8'd9}
    };

    task automatic check(input logic [3:0] exp, input int req, input string what);
        checks++;
        if ({pd, d0, d1, d2} !== exp) begin
            errors++;
            $display("FAIL R%0d %s: pins got %b expected %b", req, what, {pd, d0, d1, d2}, exp);
        end
    endtask

    task automatic cfg_write(input logic [SEL_W-1:0] sel, input logic [TW-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_row(input vec_t v);
        det_n = v.det; therm_alarm = v.alm;
        ring_req = (v.op == OP_RING); stop_req = (v.op == OP_STOP);
        pwrdn_req = (v.op == OP_PDN); wake_req = (v.op == OP_WAKE);
        pol_req = (v.op == OP_POL);
        @(posedge clk); @(negedge clk);
        ring_req = 0; stop_req = 0; pwrdn_req = 0; wake_req = 0; pol_req = 0;
        if (v.n > 0) begin
            repeat (int'(v.n)) @(posedge clk);
            @(negedge clk);
        end
        check(v.exp, int'(v.req), "vector");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(4'b1000, 1, "reset idle R1");
        // R12 program short timings
        cfg_write(3'd0, 32'd4);
        cfg_write(3'd1, 32'd40);
        cfg_write(3'd2, 32'd30);
        cfg_write(3'd3, 32'd50);
        cfg_write(3'd4, 32'd5);
        cfg_write(3'd7, 32'd1); // R12 unused select ignored
        check(4'b1000, 12, "after config R12");
        repeat (20) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NV; i++) run_row(VECS[i]);

        // R12 zero half-period stored as one: toggles every cycle
        cfg_write(3'd0, 32'd0);
        ring_req = 1'b1;
        @(posedge clk); @(negedge clk);
        ring_req = 1'b0;
        check(4'b1100, 12, "ring start zero half R12");
        @(posedge clk); @(negedge clk);
        check(4'b1101, 12, "half=1 toggle R12");
        @(posedge clk); @(negedge clk);
        check(4'b1100, 12, "half=1 toggle back R12");

        // R1 reset mid-ring returns idle
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check(4'b1000, 1, "reset during ring R1");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule